// File: doc/BRIEF.md
# Three-Phase 16-bit Instruction Sequencer Core

This block is a small, non-pipelined processor core. It steps through a strict fetch, decode and execute loop. Each instruction is a 16-bit word and takes exactly three clock cycles. The core holds sixteen 16-bit general registers, a program counter, and two status flags. Its arithmetic unit works only on register contents. Memory is reached through one synchronous port that serves both instructions and data. Read data on that port returns one cycle after the address is presented. A store is committed at the clock edge that ends the cycle in which it is presented.

A program is placed in memory, reset is applied, and then reset is released. The core fetches from address zero and runs until it executes a stop instruction. From then on it stays parked and makes no further memory accesses. A debug port shows the program counter, the two flags, the halted state, and any register chosen by a select input.

Top module: `nib_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter, all sixteen registers and both flags become zero and `halted` is 0. The first cycle after release is a fetch from address 0.
- R2: Each instruction takes three cycles in fixed order. In the fetch cycle, `mem_rd_en`=1 with `mem_addr`=PC. In the decode cycle, a read occurs only for a load. In the execute cycle, a write occurs only for a store. Read and write are never both high, and no fetch overlaps an execute.
- R3: Field positions are fixed: opcode in bits 15:12, first register A in bits 11:8, second register B in bits 7:4. Memory and branch addresses sit in bits 7:0. Codes: 0000 move, 0001 load, 0010 store, 0011 compare, 0100 jump, 0101 jump-if-zero, 0110 add, 0111 subtract, 1000 multiply, 1001 and, 1010 or, 1011 xor, 1100 not, 1101 jump-if-not-zero, 1111 stop.
- R4: Move writes B into A. Add, subtract, and, or and xor compute A op B modulo 2^16 and write the result back into A.
- R5: Multiply writes the low 16 bits of A times B into A.
- R6: Not writes the bitwise complement of B into A.
- R7: Load drives `mem_addr` = bits 7:0 with a read in the decode cycle. The word returned is written into A at the end of the execute cycle.
- R8: Store drives `mem_wr_en`=1, `mem_addr` = bits 7:0 and `mem_wdata` = A in the execute cycle. It changes no register.
- R9: Compare sets Z when A equals B. It sets N to bit 15 of (A−B) mod 2^16. It changes no register. No other instruction changes the flags. `dbg_flags` is {N, Z}.
- R10: Jump always loads PC with bits 7:0. Jump-if-zero branches when Z=1. Jump-if-not-zero branches when Z=0. A branch that is not taken advances the PC by one.
- R11: Every non-branching instruction other than stop advances the PC by exactly one, modulo 256, at the end of its execute cycle. The PC is constant during fetch and decode.
- R12: Stop (1111) and the undefined code 1110 set `halted` from the following cycle on, permanently. The PC keeps the stop instruction's address, registers and flags freeze, and both memory strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Memory word address |
| mem_rd_en | output | 1 | Read strobe; data appears on `mem_rdata` the next cycle |
| mem_wr_en | output | 1 | Write strobe; `mem_wdata` is stored at this edge |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Registered read data from memory |
| dbg_sel | input | 4 | Register index shown on `dbg_reg` |
| dbg_reg | output | 16 | Contents of the selected register (combinational) |
| dbg_pc | output | 8 | Program counter |
| dbg_flags | output | 2 | {N, Z} status flags |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bench runs an instruction-level reference model that advances one phase per clock edge and is compared with the ports at every falling edge. A fetch of instruction k is therefore expected in cycle 3k after reset release. A load address is expected in cycle 3k+1, and a store strobe in cycle 3k+2. A register or flag update, or a new PC value, is first visible in cycle 3k+3, and `halted` likewise becomes visible in cycle 3k+3. Because the model applies an instruction's whole effect only when it leaves its execute phase, each update is checked exactly one edge after that execute cycle. Directed programs add hand-computed end values, and they cover address wrap from 255 to 0, a branch loop, taken and untaken conditional branches, and halting on the undefined code.

// File: rtl/nib_pkg.sv
// Shared widths, opcode codes and phase encoding for the three-phase core.
// Assumes the fixed nibble-aligned 16-bit instruction word.
package nib_pkg;
    localparam int INSTR_W  = 16;
    localparam int OPC_W    = 4;
    localparam int RIDX_W   = 4;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = INSTR_W;
    localparam int NUM_REGS = 1 << RIDX_W;
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int RA_LSB   = OPC_LSB - RIDX_W;
    localparam int RB_LSB   = RA_LSB - RIDX_W;

    typedef enum logic [OPC_W-1:0] {
        OP_MOVE  = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_CMP   = 4'h3,
        OP_JMP   = 4'h4,
        OP_JZ    = 4'h5,
        OP_ADD   = 4'h6,
        OP_SUB   = 4'h7,
        OP_MUL   = 4'h8,
        OP_AND   = 4'h9,
        OP_OR    = 4'hA,
        OP_XOR   = 4'hB,
        OP_NOT   = 4'hC,
        OP_JNE   = 4'hD,
        OP_UNDEF = 4'hE,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_STOP   = 2'd3
    } phase_e;
endpackage

// File: rtl/nib_regfile.sv
// Register file: NUM_REGS flops of DATA_W bits, one write port,
// two combinational read ports for the datapath and one for debug.
// Assumes at most one write per cycle; synchronous active-low reset.
module nib_regfile
    import nib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b,
    input  logic [RIDX_W-1:0] raddr_dbg,
    output logic [DATA_W-1:0] rdata_dbg
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DATA_W-1:0] regs_view [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] q;
        // Hold one register; clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == RIDX_W'(i))) begin
                q <= wdata;
            end
        end
        assign regs_view[i] = q;
    end

    assign rdata_a   = regs_view[raddr_a];
    assign rdata_b   = regs_view[raddr_b];
    assign rdata_dbg = regs_view[raddr_dbg];
endmodule

// File: rtl/nib_alu.sv
// Combinational arithmetic/logic unit. Produces the write-back value for
// register-to-register opcodes and the equality/sign of A-B for compare.
// Assumes all results wrap modulo 2^DATA_W.
module nib_alu
    import nib_pkg::*;
(
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              eq,
    output logic              neg
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DATA_W-1:0] diff;

    // Select the result for the operation in execute.
    always_comb begin
        result = a;
        case (op)
            OP_MOVE: result = b;
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_MUL:  result = a * b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_XOR:  result = a ^ b;
            OP_NOT:  result = ~b;
            default: result = a;
        endcase
    end

    // Compare outcome used only by the flag register.
    always_comb begin
        diff = a - b;
        eq   = (diff == '0);
        neg  = diff[DATA_W-1];
    end
endmodule

// File: rtl/nib_sequencer.sv
// Control path: phase counter, instruction register, program counter,
// status flags and the memory strobes. Fetch, decode and execute run in
// strict order; a stop code parks the phase in PH_STOP for good.
// Assumes memory read data is registered (valid one cycle after request).
module nib_sequencer
    import nib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              alu_eq,
    input  logic              alu_neg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output opcode_e           ex_op,
    output logic [RIDX_W-1:0] ra_idx,
    output logic [RIDX_W-1:0] rb_idx,
    output logic              rf_we,
    output logic              rf_from_mem,
    output logic [ADDR_W-1:0] pc,
    output logic              flag_z,
    output logic              flag_n,
    output logic              halted
);
    timeunit 1ns;
    timeprecision 1ps;

    phase_e             phase_q;
    logic [INSTR_W-1:0] ir_q;
    logic [ADDR_W-1:0]  pc_q;
    logic               z_q;
    logic               n_q;
    opcode_e            dec_op;
    logic [ADDR_W-1:0]  ir_target;
    logic               br_taken;
    logic               stop_op;
    logic               wb_op;

    assign dec_op    = opcode_e'(mem_rdata[OPC_LSB +: OPC_W]);
    assign ex_op     = opcode_e'(ir_q[OPC_LSB +: OPC_W]);
    assign ra_idx    = ir_q[RA_LSB +: RIDX_W];
    assign rb_idx    = ir_q[RB_LSB +: RIDX_W];
    assign ir_target = ir_q[ADDR_W-1:0];
    assign stop_op   = (ex_op == OP_HALT) || (ex_op == OP_UNDEF);

    // Branch decision from the flags left by the last compare.
    always_comb begin
        case (ex_op)
            OP_JMP:  br_taken = 1'b1;
            OP_JZ:   br_taken = z_q;
            OP_JNE:  br_taken = !z_q;
            default: br_taken = 1'b0;
        endcase
    end

    // Opcodes that write a result back into register A.
    always_comb begin
        case (ex_op)
            OP_MOVE, OP_LOAD, OP_ADD, OP_SUB, OP_MUL,
            OP_AND, OP_OR, OP_XOR, OP_NOT: wb_op = 1'b1;
            default:                       wb_op = 1'b0;
        endcase
    end

    // Phase sequence: fetch, decode, execute, then fetch or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
        end else begin
            case (phase_q)
                PH_FETCH:  phase_q <= PH_DECODE;
                PH_DECODE: phase_q <= PH_EXEC;
                PH_EXEC:   phase_q <= stop_op ? PH_STOP : PH_FETCH;
                default:   phase_q <= PH_STOP;
            endcase
        end
    end

    // Capture the fetched word as it arrives during decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (phase_q == PH_DECODE) begin
            ir_q <= mem_rdata;
        end
    end

    // Advance or redirect the program counter at the end of execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if ((phase_q == PH_EXEC) && !stop_op) begin
            pc_q <= br_taken ? ir_target : pc_q + ADDR_W'(1);
        end
    end

    // Status flags change only when a compare executes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            n_q <= 1'b0;
        end else if ((phase_q == PH_EXEC) && (ex_op == OP_CMP)) begin
            z_q <= alu_eq;
            n_q <= alu_neg;
        end
    end

    // Memory strobes and address for the current phase.
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = pc_q;
        case (phase_q)
            PH_FETCH: mem_rd_en = 1'b1;
            PH_DECODE: begin
                if (dec_op == OP_LOAD) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = mem_rdata[ADDR_W-1:0];
                end
            end
            PH_EXEC: begin
                if (ex_op == OP_STORE) begin
                    mem_wr_en = 1'b1;
                    mem_addr  = ir_target;
                end
            end
            default: ;
        endcase
    end

    assign rf_we       = (phase_q == PH_EXEC) && wb_op;
    assign rf_from_mem = (ex_op == OP_LOAD);
    assign pc          = pc_q;
    assign flag_z      = z_q;
    assign flag_n      = n_q;
    assign halted      = (phase_q == PH_STOP);

    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FETCH) |=> (phase_q == PH_DECODE)); // R2
    AST_DECODE_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DECODE) |=> (phase_q == PH_EXEC)); // R2
    AST_PC_HELD_OUTSIDE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_EXEC) |=> $stable(pc_q)); // R11
    AST_FLAGS_ONLY_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        !((phase_q == PH_EXEC) && (ex_op == OP_CMP)) |=> ($stable(z_q) && $stable(n_q))); // R9
    AST_STOP_IS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_q))); // R12
    AST_STORE_IN_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (phase_q == PH_EXEC)); // R8
endmodule

// File: rtl/nib_core.sv
// Top of the three-phase 16-bit core: ties the sequencer, register file
// and ALU to the synchronous memory port and the debug outputs.
// Assumes one shared memory with registered read data.
module nib_core
    import nib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [RIDX_W-1:0] dbg_sel,
    output logic [DATA_W-1:0] dbg_reg,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [1:0]        dbg_flags,
    output logic              halted
);
    timeunit 1ns;
    timeprecision 1ps;

    opcode_e           ex_op;
    logic [RIDX_W-1:0] ra_idx;
    logic [RIDX_W-1:0] rb_idx;
    logic              rf_we;
    logic              rf_from_mem;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_res;
    logic              alu_eq;
    logic              alu_neg;
    logic              flag_z;
    logic              flag_n;

    nib_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_rdata   (mem_rdata),
        .alu_eq      (alu_eq),
        .alu_neg     (alu_neg),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .ex_op       (ex_op),
        .ra_idx      (ra_idx),
        .rb_idx      (rb_idx),
        .rf_we       (rf_we),
        .rf_from_mem (rf_from_mem),
        .pc          (dbg_pc),
        .flag_z      (flag_z),
        .flag_n      (flag_n),
        .halted      (halted)
    );

    nib_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (rf_we),
        .waddr     (ra_idx),
        .wdata     (rf_wdata),
        .raddr_a   (ra_idx),
        .rdata_a   (opnd_a),
        .raddr_b   (rb_idx),
        .rdata_b   (opnd_b),
        .raddr_dbg (dbg_sel),
        .rdata_dbg (dbg_reg)
    );

    nib_alu u_alu (
        .op     (ex_op),
        .a      (opnd_a),
        .b      (opnd_b),
        .result (alu_res),
        .eq     (alu_eq),
        .neg    (alu_neg)
    );

    // Write-back source: memory word for loads, ALU result otherwise.
    always_comb begin
        rf_wdata = rf_from_mem ? mem_rdata : alu_res;
    end

    assign mem_wdata = opnd_a;
    assign dbg_flags = {flag_n, flag_z};

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R2
    AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd_en && !mem_wr_en)); // R12
    AST_NO_WRITEBACK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(dbg_flags)); // R12
endmodule

// File: tb/nib_core_bench.sv
// Bench: memory model, instruction-level reference model compared on
// every clock, and directed programs with hand-computed end values.
module nib_core_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [3:0]  dbg_sel = '0;
    logic [15:0] dbg_reg;
    logic [7:0]  dbg_pc;
    logic [1:0]  dbg_flags;
    logic        halted;

    always #10 clk = ~clk;

    nib_core u_nib_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .dbg_sel   (dbg_sel),
        .dbg_reg   (dbg_reg),
        .dbg_pc    (dbg_pc),
        .dbg_flags (dbg_flags),
        .halted    (halted)
    );

    logic [15:0] mem [256];
    logic [15:0] ref_mem [256];

    // Synchronous memory seen by the core.
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state.
    int          m_ph;
    logic [7:0]  m_pc;
    logic [15:0] m_r [16];
    logic        m_z;
    logic        m_n;
    string       m_tag;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rr(int op, int a, int b);
        return {4'(op), 4'(a), 4'(b), 4'h0};
    endfunction

    function automatic logic [15:0] ma(int op, int a, int adr);
        return {4'(op), 4'(a), 8'(adr)};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            ref_mem[i] = '0;
        end
    endtask

    task automatic put(int adr, logic [15:0] v);
        mem[adr] = v;
        ref_mem[adr] = v;
    endtask

    task automatic peek_reg(int idx, output logic [15:0] v);
        @(negedge clk);
        dbg_sel = 4'(idx);
        #1;
        v = dbg_reg;
    endtask

    // Compare ports against the model for the current cycle.
    task automatic compare_cycle(int cyc);
        logic [15:0] ins;
        logic [3:0]  op;
        ins = ref_mem[m_pc];
        op  = ins[15:12];
        dbg_sel = 4'(cyc);
        #1;
        check("R11", "pc", 32'(dbg_pc), 32'(m_pc));
        check("R12", "halted", 32'(halted), 32'(m_ph == 3));
        check(m_tag, "register", 32'(dbg_reg), 32'(m_r[dbg_sel]));
        check("R9", "flags", 32'(dbg_flags), 32'({m_n, m_z}));
        case (m_ph)
            0: begin
                check("R2", "fetch rd", 32'(mem_rd_en), 32'd1);
                check("R2", "fetch wr", 32'(mem_wr_en), 32'd0);
                check("R2", "fetch addr", 32'(mem_addr), 32'(m_pc));
            end
            1: begin
                check("R7", "decode rd", 32'(mem_rd_en), 32'(op == 4'h1));
                check("R2", "decode wr", 32'(mem_wr_en), 32'd0);
                if (op == 4'h1) check("R3", "load addr field", 32'(mem_addr), 32'(ins[7:0]));
            end
            2: begin
                check("R2", "exec rd", 32'(mem_rd_en), 32'd0);
                check("R8", "exec wr", 32'(mem_wr_en), 32'(op == 4'h2));
                if (op == 4'h2) begin
                    check("R8", "store addr", 32'(mem_addr), 32'(ins[7:0]));
                    check("R8", "store data", 32'(mem_wdata), 32'(m_r[ins[11:8]]));
                end
            end
            default: begin
                check("R12", "stopped rd", 32'(mem_rd_en), 32'd0);
                check("R12", "stopped wr", 32'(mem_wr_en), 32'd0);
            end
        endcase
    endtask

    // Advance the model by one clock edge.
    task automatic model_step();
        logic [15:0] ins;
        logic [3:0]  op;
        logic [3:0]  a;
        logic [3:0]  b;
        logic [7:0]  t;
        logic [7:0]  nxt;
        logic [15:0] d;
        case (m_ph)
            0: m_ph = 1;
            1: m_ph = 2;
            2: begin
                ins = ref_mem[m_pc];
                op = ins[15:12]; a = ins[11:8]; b = ins[7:4]; t = ins[7:0];
                nxt = m_pc + 8'd1;
                m_ph = 0;
                case (op)
                    4'h0: begin m_r[a] = m_r[b]; m_tag = "R4"; end
                    4'h1: begin m_r[a] = ref_mem[t]; m_tag = "R7"; end
                    4'h2: begin ref_mem[t] = m_r[a]; m_tag = "R8"; end
                    4'h3: begin
                        d = m_r[a] - m_r[b];
                        m_z = (d == 16'd0);
                        m_n = d[15];
                        m_tag = "R9";
                    end
                    4'h4: begin nxt = t; m_tag = "R10"; end
                    4'h5: begin if (m_z) nxt = t; m_tag = "R10"; end
                    4'hD: begin if (!m_z) nxt = t; m_tag = "R10"; end
                    4'h6: begin m_r[a] = m_r[a] + m_r[b]; m_tag = "R4"; end
                    4'h7: begin m_r[a] = m_r[a] - m_r[b]; m_tag = "R4"; end
                    4'h8: begin m_r[a] = m_r[a] * m_r[b]; m_tag = "R5"; end
                    4'h9: begin m_r[a] = m_r[a] & m_r[b]; m_tag = "R4"; end
                    4'hA: begin m_r[a] = m_r[a] | m_r[b]; m_tag = "R4"; end
                    4'hB: begin m_r[a] = m_r[a] ^ m_r[b]; m_tag = "R4"; end
                    4'hC: begin m_r[a] = ~m_r[b]; m_tag = "R6"; end
                    default: begin m_ph = 3; nxt = m_pc; m_tag = "R12"; end
                endcase
                m_pc = nxt;
            end
            default: m_ph = 3;
        endcase
    endtask

    // Reset, check reset state, run until stopped plus a quiet tail.
    task automatic run_prog(output int first_halt);
        int tail;
        int mism;
        first_halt = -1;
        tail = 0;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            dbg_sel = 4'(i);
            #1;
            check("R1", "reset register", 32'(dbg_reg), 32'd0);
        end
        check("R1", "reset pc", 32'(dbg_pc), 32'd0);
        check("R1", "reset halted", 32'(halted), 32'd0);
        check("R1", "reset flags", 32'(dbg_flags), 32'd0);
        m_ph = 0; m_pc = '0; m_z = 1'b0; m_n = 1'b0; m_tag = "R1";
        for (int i = 0; i < 16; i++) m_r[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            compare_cycle(c);
            if (halted && first_halt < 0) first_halt = c;
            model_step();
            if (m_ph == 3) tail++;
            if (tail > 8) break;
            @(negedge clk);
        end
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
        check("R8", "memory image mismatches", 32'(mism), 32'd0);
    endtask

    initial begin
        int fh;
        logic [15:0] v;

        // Program 1: data movement, arithmetic and logic.
        clear_mem();
        put(8'h00, ma(1, 1, 8'h80));
        put(8'h01, ma(1, 2, 8'h81));
        put(8'h02, rr(0, 3, 1));
        put(8'h03, rr(6, 3, 2));
        put(8'h04, rr(7, 4, 1));
        put(8'h05, rr(0, 5, 1));
        put(8'h06, rr(8, 5, 2));
        put(8'h07, ma(1, 6, 8'h82));
        put(8'h08, rr(6, 6, 6));
        put(8'h09, rr(12, 8, 2));
        put(8'h0A, rr(0, 9, 1));
        put(8'h0B, rr(9, 9, 2));
        put(8'h0C, rr(0, 10, 1));
        put(8'h0D, rr(10, 10, 2));
        put(8'h0E, rr(0, 11, 1));
        put(8'h0F, rr(11, 11, 2));
        put(8'h10, ma(2, 3, 8'h90));
        put(8'h11, ma(2, 5, 8'h91));
        put(8'h12, 16'hF000);
        put(8'h80, 16'h1234);
        put(8'h81, 16'h00F0);
        put(8'h82, 16'hFFFF);
        run_prog(fh);
        check("R2", "cycles to halted for 19 instructions", 32'(fh), 32'd57);
        check("R4", "stored sum", 32'(mem[8'h90]), 32'h1324);
        check("R5", "stored product low half", 32'(mem[8'h91]), 32'h10C0);
        peek_reg(4, v);  check("R4", "sub wrap", 32'(v), 32'hEDCC);
        peek_reg(6, v);  check("R4", "add overflow", 32'(v), 32'hFFFE);
        peek_reg(8, v);  check("R6", "not", 32'(v), 32'hFF0F);
        peek_reg(9, v);  check("R4", "and", 32'(v), 32'h0030);
        peek_reg(10, v); check("R4", "or", 32'(v), 32'h12F4);
        peek_reg(11, v); check("R4", "xor", 32'(v), 32'h12C4);
        check("R12", "pc parked on stop", 32'(dbg_pc), 32'h12);

        // Program 2: compare and branch loop, undefined code halts.
        clear_mem();
        put(8'h00, ma(1, 1, 8'h80));
        put(8'h01, ma(1, 2, 8'h81));
        put(8'h02, ma(1, 7, 8'h82));
        put(8'h03, rr(6, 4, 7));
        put(8'h04, rr(7, 1, 2));
        put(8'h05, rr(3, 1, 0));
        put(8'h06, ma(13, 0, 8'h03));
        put(8'h07, rr(3, 1, 2));
        put(8'h08, ma(5, 0, 8'h0A));
        put(8'h09, ma(4, 0, 8'h0B));
        put(8'h0A, ma(2, 4, 8'h90));
        put(8'h0B, rr(3, 2, 2));
        put(8'h0C, ma(5, 0, 8'h0E));
        put(8'h0D, 16'hF000);
        put(8'h0E, ma(2, 4, 8'h91));
        put(8'h0F, 16'hE000);
        put(8'h80, 16'd3);
        put(8'h81, 16'd1);
        put(8'h82, 16'd5);
        run_prog(fh);
        check("R10", "loop result stored after taken jump-if-zero", 32'(mem[8'h91]), 32'd15);
        check("R10", "skipped store left memory untouched", 32'(mem[8'h90]), 32'd0);
        check("R12", "undefined code halts at its address", 32'(dbg_pc), 32'h0F);
        check("R9", "flags after equal compare", 32'(dbg_flags), 32'b01);
        peek_reg(1, v); check("R9", "compare left counter intact", 32'(v), 32'd0);

        // Program 3: PC wrap from 255 to 0 and negative compare.
        clear_mem();
        put(8'h00, rr(3, 0, 1));
        put(8'h01, ma(5, 0, 8'hFE));
        put(8'h02, ma(2, 2, 8'h90));
        put(8'h03, 16'hF000);
        put(8'hFE, ma(1, 1, 8'h80));
        put(8'hFF, rr(0, 2, 1));
        put(8'h80, 16'd7);
        run_prog(fh);
        check("R11", "wrap reached address 2 store", 32'(mem[8'h90]), 32'd7);
        check("R9", "negative compare flags", 32'(dbg_flags), 32'b10);
        check("R12", "pc parked after wrap", 32'(dbg_pc), 32'h03);
        check("R12", "halted held", 32'(halted), 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule